// File: doc/BRIEF.md
# Interleaved Two-Memory Pixel Delay Line

This block delays a stream of 8-bit pixels by a programmable number of clock cycles. A new pixel enters on every cycle and the pixel that entered D cycles earlier leaves on every cycle. Two external single-port memories hold the delayed data. Each memory has a 16-bit word. Neither memory can take one store and one load per cycle, and each one needs an idle cycle between a write and a following read.

The stream is cut into pairs of pixels. Each pair is packed into one 16-bit word. Even pairs (stream positions 0 and 1 modulo 4) go to memory A and odd pairs (positions 2 and 3 modulo 4) go to memory B. A four-slot schedule repeats without end. In slot SL_2, lane A writes its pair, and in slot SL_0 it reads a pair back. Lane B follows the same pattern two slots later, writing in SL_0 and reading in SL_2. As a result, each memory performs one write and one read every four cycles, and there is always an idle cycle after each access. Output holding registers release the two bytes of each word read back on consecutive cycles, in the original order.

A mode machine tracks whether the line is filled. After reset or a restart it starts in MD_FILL, with the output marked invalid. It moves MD_FILL to MD_STREAM on the cycle that ends the first D cycles, and it stays in MD_STREAM until the next restart. The slot sequence is SL_0 to SL_1 to SL_2 to SL_3 and back to SL_0, and the group counter advances on the transition out of SL_3. Loading a new length restarts the line. This forces the slot to SL_0 and the mode to MD_FILL.

Top module: `dl_delay_line`

## Requirements
- R1: While `pix_out_vld` is high, `pix_out` in cycle c equals the `pix_in` value of cycle c−D, where D is the active delay length.
- R2: After a reset or an accepted length load, `pix_out_vld` is low for exactly D cycles and high from then on. The first of these cycles is the one following the reset release or the load.
- R3: A length is accepted when it is a multiple of 4, at least 8, and at most 4·2^AW. An accepted load takes effect at the next clock edge and restarts the line. The pixel presented in the load cycle is dropped, and the pixel of the next cycle is the first one delayed.
- R4: A load with any other length is ignored. The delay and the output stream continue unchanged.
- R5: Each memory write carries one pair packed into a single 16-bit word, with the earlier pixel in bits 7:0 and the later pixel in bits 15:8. Counting cycles from the restart, memory A writes in the cycles that are 2 modulo 4 and stores the pixels of the two previous cycles. Memory B does the same in the cycles that are 0 modulo 4, from cycle 4 on.
- R6: No memory sees a read in the cycle directly after a write.
- R7: No memory is accessed, by either a read or a write, in two consecutive cycles. This keeps each memory within two accesses in any three cycles.
- R8: A memory never has read and write requested together.
- R9: Reset leaves both write enables low and `pix_out_vld` low, and sets the delay to 8.
- R10: Both extreme lengths, 8 and 4·2^AW, give an exact delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_in | input | PW | Incoming pixel, one per cycle |
| cfg_load | input | 1 | Strobe to load a new delay length |
| cfg_len | input | AW+3 | Requested delay length in cycles |
| pix_out | output | PW | Delayed pixel |
| pix_out_vld | output | 1 | Delayed pixel is valid |
| a_addr | output | AW | Memory A word address |
| a_we | output | 1 | Memory A write request |
| a_re | output | 1 | Memory A read request |
| a_wdata | output | 2·PW | Memory A write word |
| a_rdata | input | 2·PW | Memory A read word, registered one cycle after `a_re` |
| b_addr | output | AW | Memory B word address |
| b_we | output | 1 | Memory B write request |
| b_re | output | 1 | Memory B read request |
| b_wdata | output | 2·PW | Memory B write word |
| b_rdata | input | 2·PW | Memory B read word, registered one cycle after `b_re` |

## Verification
The bench keeps a count of cycles since the last restart and stores every pixel it drives. In cycle c it expects the pixel from cycle c−D on the output, and it expects the valid flag to be high exactly when c ≥ D. A pair written to memory is due two cycles after its first pixel. A read word is due one cycle after the read request, and it appears on the output four cycles after that request. All outputs are sampled on the falling edge of the cycle they belong to, and the memory models update on the rising edge. Turnaround and access spacing are compared against the previous cycle's port values, so a write followed directly by a read is reported in the cycle the read appears.

// File: rtl/dl_pkg.sv
package dl_pkg;
    // Position inside the repeating four-cycle schedule
    typedef enum logic [1:0] {SL_0, SL_1, SL_2, SL_3} slot_e;
    // Fill state of the line
    typedef enum logic {MD_FILL, MD_STREAM} mode_e;
    // Shortest length the read/write schedule can serve
    localparam int unsigned DL_MIN_LEN = 8;
endpackage

// File: rtl/dl_sched.sv
module dl_sched
    import dl_pkg::*;
#(
    parameter int AW = 6,
    localparam int LW = AW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [LW-1:0] dly,
    output slot_e         slot,
    output logic [AW-1:0] grp,
    output logic          out_vld
);
    mode_e         mode_q, mode_n;
    slot_e         slot_q, slot_n;
    logic [AW-1:0] grp_q, grp_n;
    logic [LW-1:0] cnt_q, cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_FILL;
            slot_q <= SL_0;
            grp_q  <= '0;
            cnt_q  <= '0;
        end else if (restart) begin
            mode_q <= MD_FILL;
            slot_q <= SL_0;
            grp_q  <= '0;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_n;
            slot_q <= slot_n;
            grp_q  <= grp_n;
            cnt_q  <= cnt_n;
        end
    end

    // transitions and outputs
    always_comb begin
        slot_n = slot_q;
        grp_n  = grp_q;
        unique case (slot_q)
            SL_0: slot_n = SL_1;
            SL_1: slot_n = SL_2;
            SL_2: slot_n = SL_3;
            SL_3: begin
                slot_n = SL_0;
                grp_n  = grp_q + AW'(1);
            end
        endcase

        mode_n = mode_q;
        cnt_n  = cnt_q;
        unique case (mode_q)
            MD_FILL: begin
                cnt_n = cnt_q + LW'(1);
                if (cnt_q == dly - LW'(1)) mode_n = MD_STREAM;
            end
            MD_STREAM: mode_n = MD_STREAM;
        endcase

        slot    = slot_q;
        grp     = grp_q;
        out_vld = (mode_q == MD_STREAM);
    end
endmodule

// File: rtl/dl_lane.sv
module dl_lane
    import dl_pkg::*;
#(
    parameter int PW   = 8,
    parameter int AW   = 6,
    parameter int LANE = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  slot_e           slot,
    input  logic [AW-1:0]   grp,
    input  logic [AW-1:0]   koff,
    input  logic [PW-1:0]   pix,
    output logic [AW-1:0]   m_addr,
    output logic            m_we,
    output logic            m_re,
    output logic [2*PW-1:0] m_wdata,
    input  logic [2*PW-1:0] m_rdata,
    output logic [2*PW-1:0] rd_word
);
    localparam logic [1:0] SHIFT = 2'(2 * LANE);

    logic [1:0]    rel_raw;
    slot_e         rel;
    logic [PW-1:0] lo_q, hi_q;
    logic [AW-1:0] pgrp_q;
    logic          pvld_q;
    logic          wdone_q;

    assign rel_raw = slot - SHIFT;
    assign rel     = slot_e'(rel_raw);

    // pair capture, read word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            pgrp_q  <= '0;
            pvld_q  <= 1'b0;
            wdone_q <= 1'b0;
            rd_word <= '0;
        end else if (restart) begin
            pvld_q  <= 1'b0;
            wdone_q <= 1'b0;
        end else begin
            unique case (rel)
                SL_0: lo_q <= pix;
                SL_1: begin
                    hi_q    <= pix;
                    pgrp_q  <= grp;
                    pvld_q  <= 1'b1;
                    rd_word <= m_rdata;
                end
                SL_2: if (pvld_q) wdone_q <= 1'b1;
                SL_3: ;
            endcase
        end
    end

    // memory port outputs
    always_comb begin
        m_we    = 1'b0;
        m_re    = 1'b0;
        m_addr  = pgrp_q;
        m_wdata = {hi_q, lo_q};
        unique case (rel)
            SL_0: begin
                m_re   = wdone_q;
                m_addr = grp - koff;
            end
            SL_2: m_we = pvld_q;
            SL_1, SL_3: ;
        endcase
    end
endmodule

// File: rtl/dl_delay_line.sv
module dl_delay_line
    import dl_pkg::*;
#(
    parameter int AW      = 6,
    parameter int PW      = 8,
    parameter int RST_DLY = 8,
    localparam int LW = AW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   pix_in,
    input  logic            cfg_load,
    input  logic [LW-1:0]   cfg_len,
    output logic [PW-1:0]   pix_out,
    output logic            pix_out_vld,
    output logic [AW-1:0]   a_addr,
    output logic            a_we,
    output logic            a_re,
    output logic [2*PW-1:0] a_wdata,
    input  logic [2*PW-1:0] a_rdata,
    output logic [AW-1:0]   b_addr,
    output logic            b_we,
    output logic            b_re,
    output logic [2*PW-1:0] b_wdata,
    input  logic [2*PW-1:0] b_rdata
);
    localparam logic [LW-1:0] MIN_L = LW'(DL_MIN_LEN);
    localparam logic [LW-1:0] MAX_L = LW'(4 * (2 ** AW));

    logic [LW-1:0]   dly_q;
    logic            legal, restart;
    logic [AW-1:0]   koff;
    slot_e           slot;
    logic [AW-1:0]   grp;
    logic [AW-1:0]   addr_v  [2];
    logic            we_v    [2];
    logic            re_v    [2];
    logic [2*PW-1:0] wdata_v [2];
    logic [2*PW-1:0] rdata_v [2];
    logic [2*PW-1:0] word_v  [2];

    assign legal   = (cfg_len[1:0] == 2'b00) && (cfg_len >= MIN_L) && (cfg_len <= MAX_L);
    assign restart = cfg_load && legal;
    assign koff    = dly_q[AW+1:2] - AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dly_q <= LW'(RST_DLY);
        else if (restart) dly_q <= cfg_len;
    end

    dl_sched #(.AW(AW)) u_sched (
        .clk(clk), .rst_n(rst_n), .restart(restart), .dly(dly_q),
        .slot(slot), .grp(grp), .out_vld(pix_out_vld)
    );

    assign rdata_v[0] = a_rdata;
    assign rdata_v[1] = b_rdata;

    for (genvar L = 0; L < 2; L++) begin : g_lane
        dl_lane #(.PW(PW), .AW(AW), .LANE(L)) u_lane (
            .clk(clk), .rst_n(rst_n), .restart(restart), .slot(slot),
            .grp(grp), .koff(koff), .pix(pix_in),
            .m_addr(addr_v[L]), .m_we(we_v[L]), .m_re(re_v[L]),
            .m_wdata(wdata_v[L]), .m_rdata(rdata_v[L]), .rd_word(word_v[L])
        );
    end

    assign a_addr  = addr_v[0];
    assign a_we    = we_v[0];
    assign a_re    = re_v[0];
    assign a_wdata = wdata_v[0];
    assign b_addr  = addr_v[1];
    assign b_we    = we_v[1];
    assign b_re    = re_v[1];
    assign b_wdata = wdata_v[1];

    // byte release in stream order
    always_comb begin
        unique case (slot)
            SL_0: pix_out = word_v[0][PW-1:0];
            SL_1: pix_out = word_v[0][2*PW-1:PW];
            SL_2: pix_out = word_v[1][PW-1:0];
            SL_3: pix_out = word_v[1][2*PW-1:PW];
        endcase
    end
endmodule

// File: rtl/dl_delay_line_chk.sv
module dl_delay_line_chk #(
    parameter int AW = 6,
    parameter int PW = 8,
    localparam int LW = AW + 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PW-1:0]   pix_in,
    input logic            cfg_load,
    input logic [LW-1:0]   cfg_len,
    input logic [LW-1:0]   dly_q,
    input logic            pix_out_vld,
    input logic            a_we,
    input logic            a_re,
    input logic [2*PW-1:0] a_wdata,
    input logic            b_we,
    input logic            b_re,
    input logic [2*PW-1:0] b_wdata
);
    logic bad_len;
    assign bad_len = (cfg_len[1:0] != 2'b00) || (cfg_len < LW'(8)) || (cfg_len > LW'(4 * (2 ** AW)));

    // R6
    a_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n) a_we |=> !a_re);
    // R6
    b_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n) b_we |=> !b_re);
    // R7
    a_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n) (a_we || a_re) |=> !(a_we || a_re));
    // R7
    b_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n) (b_we || b_re) |=> !(b_we || b_re));
    // R8
    a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(a_we && a_re));
    // R8
    b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(b_we && b_re));
    // R5
    a_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_we |-> (a_wdata == {$past(pix_in, 1), $past(pix_in, 2)}));
    // R5
    b_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_we |-> (b_wdata == {$past(pix_in, 1), $past(pix_in, 2)}));
    // R4
    bad_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && bad_len) |=> $stable(dly_q));
    // R2
    vld_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_out_vld && !cfg_load) |=> pix_out_vld);
endmodule

bind dl_delay_line dl_delay_line_chk #(.AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .cfg_load(cfg_load),
    .cfg_len(cfg_len), .dly_q(dly_q), .pix_out_vld(pix_out_vld),
    .a_we(a_we), .a_re(a_re), .a_wdata(a_wdata),
    .b_we(b_we), .b_re(b_re), .b_wdata(b_wdata)
);

// File: tb/dl_delay_line_tb_top.sv
module dl_delay_line_tb_top;
    localparam int AW    = 6;
    localparam int PW    = 8;
    localparam int LW    = AW + 3;
    localparam int DEPTH = 2 ** AW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PW-1:0]   pix_in = '0;
    logic            cfg_load = 1'b0;
    logic [LW-1:0]   cfg_len = '0;
    logic [PW-1:0]   pix_out;
    logic            pix_out_vld;
    logic [AW-1:0]   a_addr, b_addr;
    logic            a_we, a_re, b_we, b_re;
    logic [2*PW-1:0] a_wdata, b_wdata;
    logic [2*PW-1:0] a_rdata = '0, b_rdata = '0;
    logic [2*PW-1:0] mem_a [DEPTH];
    logic [2*PW-1:0] mem_b [DEPTH];

    always #5 clk = ~clk;

    dl_delay_line #(.AW(AW), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .cfg_load(cfg_load), .cfg_len(cfg_len),
        .pix_out(pix_out), .pix_out_vld(pix_out_vld),
        .a_addr(a_addr), .a_we(a_we), .a_re(a_re), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_we(b_we), .b_re(b_re), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    // single-port memory models, registered read
    always @(posedge clk) begin
        if (a_we) mem_a[a_addr] <= a_wdata;
        if (a_re) a_rdata <= mem_a[a_addr];
        if (b_we) mem_b[b_addr] <= b_wdata;
        if (b_re) b_rdata <= mem_b[b_addr];
    end

    int checks = 0;
    int errors = 0;
    int c = 0;
    int dcur = 8;
    int pcount = 0;
    logic [PW-1:0] hist [$];
    bit prev_awe = 0, prev_bwe = 0, prev_aacc = 0, prev_bacc = 0;
    string vtag = "R9";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at t=%0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic bit len_ok(input int len);
        return (len % 4 == 0) && (len >= 8) && (len <= 4 * DEPTH);
    endfunction

    // one cycle: check the current cycle, then drive the inputs of this cycle
    task automatic step(input logic [PW-1:0] pix, input bit load, input int len);
        int exp_pix;
        int exp_w;
        chk(pix_out_vld == (c >= dcur), vtag, int'(pix_out_vld), int'(c >= dcur));
        if (c >= dcur) begin
            exp_pix = int'(hist[c - dcur]);
            chk(int'(pix_out) == exp_pix, "R1", int'(pix_out), exp_pix);
        end
        exp_w = (c >= 2) ? int'({hist[c-1], hist[c-2]}) : -1;
        if (a_we) chk((c % 4 == 2) && int'(a_wdata) == exp_w, "R5", int'(a_wdata), exp_w);
        if (b_we) chk((c % 4 == 0) && (c >= 4) && int'(b_wdata) == exp_w, "R5", int'(b_wdata), exp_w);
        chk(!(prev_awe && a_re) && !(prev_bwe && b_re), "R6", int'({a_re, b_re}), 0);
        chk(!(prev_aacc && (a_we || a_re)) && !(prev_bacc && (b_we || b_re)), "R7",
            int'({a_we | a_re, b_we | b_re}), 0);
        chk(!(a_we && a_re) && !(b_we && b_re), "R8", int'({a_we & a_re, b_we & b_re}), 0);
        prev_awe  = a_we;
        prev_bwe  = b_we;
        prev_aacc = a_we || a_re;
        prev_bacc = b_we || b_re;
        pix_in   = pix;
        cfg_load = load;
        cfg_len  = LW'(len);
        hist.push_back(pix);
        if (load && len_ok(len)) begin
            dcur = len;
            c = 0;
            hist.delete();
        end else begin
            c++;
        end
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            step(PW'(pcount * 37 + (pcount >> 3) + 11), 1'b0, 0);
            pcount++;
        end
    endtask

    task automatic load(input int len);
        step(PW'(8'hA5), 1'b1, len);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_a[i] = '0;
            mem_b[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(pix_out_vld == 1'b0, "R9", int'(pix_out_vld), 0);
        chk(!a_we && !b_we, "R9", int'({a_we, b_we}), 0);
        rst_n = 1'b1;
        c = 0;
        dcur = 8;
        // R9: default length 8 after reset
        vtag = "R9";
        run(60);
        // R4: rejected lengths leave the stream running with the old delay
        vtag = "R4";
        load(10);
        run(30);
        load(4);
        run(30);
        load(4 * DEPTH + 4);
        run(30);
        // R3: accepted length restarts the line
        vtag = "R3";
        load(12);
        run(80);
        // R10: longest length
        vtag = "R10";
        load(4 * DEPTH);
        run(4 * DEPTH + 200);
        // R10: shortest length, loaded mid-stream at various slots
        load(8);
        run(41);
        vtag = "R2";
        load(20);
        run(13);
        load(16);
        run(90);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule